// File: doc/BRIEF.md
# Shared-Bus Hand-Over Controller

This block lets two bus masters share one external memory bus through a three-wire handshake: a hold request, a hold acknowledge, and a bus-request line. It can take one of two roles. In the owning role, which is the default, the block holds the bus. It hands the bus to a requester that raises hold once the local bus sequencer reports idle, and it raises its own request line while it is waiting to get the bus back. In the borrowing role the acknowledge line becomes an input. The block asks for the bus and drives it only while the acknowledge from the owner is present.

Two instances, one in each role, connect pin to pin. The owner's acknowledge output goes to the borrower's acknowledge input, and each device's request line goes to the other device's hold input. Both handshake inputs pass through a synchroniser before the role logic uses them. Arbitration is off until an enable bit is set. While it is off the block owns the bus and keeps all handshake outputs quiet. All handshake signals are active high at the block's ports, and the pad ring handles pin polarity.

Top module: `bus_share_arbiter`

## Requirements
- R1: With `arb_en` low, `breq_o`, `hlda_o` and `hlda_oe` are 0 and `bus_drv_en` is 1, whatever `hold_i` does.
- R2: After reset, with `arb_en` high and `slave_mode` low, the block is in the owning role: `hlda_oe`=1, `bus_drv_en`=1, `hlda_o`=0 and `breq_o`=0.
- R3: With `arb_en` and `slave_mode` both high, `hlda_oe` is 0 (acknowledge is an input) and `hlda_o` is 0.
- R4: In the owning role, a synchronised hold is honoured only while `seq_busy` is 0. On the grant, `bus_drv_en` goes to 0 and `hlda_o` goes to 1 in the same cycle. While the sequencer stays busy, the bus stays driven.
- R5: In the owning role, `breq_o` equals `acc_pending` while the bus is granted away, and is 0 at all other times.
- R6: When the synchronised hold falls, `hlda_o` goes to 0 with `bus_drv_en` still 0. `bus_drv_en` returns to 1 exactly one cycle later.
- R7: `hold_i` and `hlda_i` each pass through two flops. A change in the input is acted on at the third rising edge after it.
- R8: In the borrowing role, `breq_o` follows `acc_pending`. `bus_drv_en` rises only when the synchronised grant and `acc_pending` are both high. Once driving, the block keeps driving while `seq_busy` is 1, and releases when the grant is low and `seq_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_en | input | 1 | Arbitration enable |
| slave_mode | input | 1 | 1 = borrowing role, 0 = owning role |
| seq_busy | input | 1 | Bus sequencer is in the middle of a cycle |
| acc_pending | input | 1 | An internal access is waiting for the bus |
| hold_i | input | 1 | Hold request from the other master (asynchronous) |
| hlda_i | input | 1 | Grant from the owner, used in the borrowing role (asynchronous) |
| breq_o | output | 1 | Bus request to the other master |
| hlda_o | output | 1 | Grant to the other master, used in the owning role |
| hlda_oe | output | 1 | Output enable of the acknowledge pin |
| bus_drv_en | output | 1 | Enable for the address, data and strobe drivers |

## Verification
The hardest case to reach is the gap cycle on reclaim, where the acknowledge has already dropped and the drivers are still off. It lasts one cycle and only follows a full grant round. The stimulus holds the sequencer busy while hold rises, so the refusal can be observed first. It then frees the sequencer, raises a pending access while the bus is away, and removes hold. Samples are taken at each of the three synchroniser edges, so the gap cycle and the cycle that restores the drivers are checked separately. The borrowing role is driven in the same way, with the grant withdrawn while the sequencer is still busy.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  typedef enum logic [1:0] {
    MS_OWN     = 2'd0,
    MS_LENT    = 2'd1,
    MS_RECLAIM = 2'd2
  } mst_state_e;

  typedef enum logic {
    SL_WAIT  = 1'b0,
    SL_DRIVE = 1'b1
  } slv_state_e;

  function automatic mst_state_e fn_mst_next(mst_state_e cur, logic hold_s, logic busy);
    mst_state_e nxt;
    nxt = cur;
    unique case (cur)
      MS_OWN:     if (hold_s && !busy) nxt = MS_LENT;
      MS_LENT:    if (!hold_s) nxt = MS_RECLAIM;
      MS_RECLAIM: nxt = MS_OWN;
      default:    nxt = MS_OWN;
    endcase
    return nxt;
  endfunction

  function automatic slv_state_e fn_slv_next(slv_state_e cur, logic grant_s,
                                             logic want, logic busy);
    slv_state_e nxt;
    nxt = cur;
    unique case (cur)
      SL_WAIT:  if (grant_s && want) nxt = SL_DRIVE;
      SL_DRIVE: if (!grant_s && !busy) nxt = SL_WAIT;
      default:  nxt = SL_WAIT;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/bsa_sync.sv
module bsa_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d_async;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= '0;
      else        chain[g] <= chain[g-1];
    end
  end

  assign q_sync = chain[LAST];
endmodule

// File: rtl/bsa_master_fsm.sv
module bsa_master_fsm
  import bsa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic hold_s,
  input  logic seq_busy,
  input  logic acc_pending,
  output logic drv_en,
  output logic grant_out,
  output logic req_out
);
  mst_state_e state_q, state_d;

  always_comb begin
    state_d = fn_mst_next(state_q, hold_s, seq_busy);
    if (!active) state_d = MS_OWN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MS_OWN;
    else        state_q <= state_d;
  end

  assign drv_en    = (state_q == MS_OWN);
  assign grant_out = (state_q == MS_LENT);
  assign req_out   = grant_out && acc_pending;

  // Named events for the checks below
  logic ev_grant_rise;
  logic ev_grant_fall;
  assign ev_grant_rise = (state_q == MS_OWN)  && (state_d == MS_LENT);
  assign ev_grant_fall = (state_q == MS_LENT) && (state_d == MS_RECLAIM);

  AST_GRANT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ev_grant_rise) |-> !seq_busy) else $error("grant while busy"); // R4
  AST_BUSY_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && drv_en && seq_busy) |=> drv_en) else $error("bus lost while busy"); // R4
  AST_NO_DUAL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_out |-> !drv_en) else $error("grant with drivers on"); // R4
  AST_RECLAIM_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $fell(grant_out)) |-> (!drv_en ##1 drv_en)) else $error("reclaim gap"); // R6
  AST_REQ_ONLY_LENT: assert property (@(posedge clk) disable iff (!rst_n)
    req_out |-> grant_out) else $error("request while owning"); // R5
endmodule

// File: rtl/bsa_slave_fsm.sv
module bsa_slave_fsm
  import bsa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic grant_s,
  input  logic seq_busy,
  input  logic acc_pending,
  output logic drv_en,
  output logic req_out
);
  slv_state_e state_q, state_d;

  always_comb begin
    state_d = fn_slv_next(state_q, grant_s, acc_pending, seq_busy);
    if (!active) state_d = SL_WAIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SL_WAIT;
    else        state_q <= state_d;
  end

  assign drv_en  = (state_q == SL_DRIVE);
  assign req_out = active && acc_pending;

  AST_SLV_TAKE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> $past(grant_s && acc_pending)) else $error("took bus without grant"); // R8
  AST_SLV_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (active && drv_en && seq_busy) |=> drv_en) else $error("dropped bus mid-cycle"); // R8
endmodule

// File: rtl/bus_share_arbiter.sv
module bus_share_arbiter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arb_en,
  input  logic slave_mode,
  input  logic seq_busy,
  input  logic acc_pending,
  input  logic hold_i,
  input  logic hlda_i,
  output logic breq_o,
  output logic hlda_o,
  output logic hlda_oe,
  output logic bus_drv_en
);
  localparam int NSYNC = 2;

  logic [NSYNC-1:0] hs_raw, hs_sync;
  logic hold_s, grant_s;
  logic mst_act, slv_act;
  logic m_drv, m_grant, m_req;
  logic s_drv, s_req;

  assign hs_raw  = {hold_i, hlda_i};
  assign hold_s  = hs_sync[1];
  assign grant_s = hs_sync[0];
  assign mst_act = arb_en && !slave_mode;
  assign slv_act = arb_en && slave_mode;

  bsa_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(hs_raw), .q_sync(hs_sync)
  );

  bsa_master_fsm u_mst (
    .clk(clk), .rst_n(rst_n), .active(mst_act), .hold_s(hold_s),
    .seq_busy(seq_busy), .acc_pending(acc_pending),
    .drv_en(m_drv), .grant_out(m_grant), .req_out(m_req)
  );

  bsa_slave_fsm u_slv (
    .clk(clk), .rst_n(rst_n), .active(slv_act), .grant_s(grant_s),
    .seq_busy(seq_busy), .acc_pending(acc_pending),
    .drv_en(s_drv), .req_out(s_req)
  );

  always_comb begin
    if (!arb_en)         bus_drv_en = 1'b1;
    else if (slave_mode) bus_drv_en = s_drv;
    else                 bus_drv_en = m_drv;
  end

  assign breq_o  = mst_act ? m_req : (slv_act ? s_req : 1'b0);
  assign hlda_o  = mst_act && m_grant;
  assign hlda_oe = mst_act;

  AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_en |-> (!breq_o && !hlda_o && bus_drv_en)) else $error("active while disabled"); // R1
  AST_SLAVE_PIN_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_en && slave_mode) |-> (!hlda_oe && !hlda_o)) else $error("ack driven in slave"); // R3
endmodule

// File: tb/bus_share_arbiter_bench.sv
`timescale 1ns/100ps
module bus_share_arbiter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arb_en = 1'b0, slave_mode = 1'b0, seq_busy = 1'b0, acc_pending = 1'b0;
  logic hold_i = 1'b0, hlda_i = 1'b0;
  logic breq_o, hlda_o, hlda_oe, bus_drv_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string tag;
    logic  drv;
    logic  ack;
    logic  oe;
    logic  req;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  bus_share_arbiter u_bus_share_arbiter (
    .clk(clk), .rst_n(rst_n), .arb_en(arb_en), .slave_mode(slave_mode),
    .seq_busy(seq_busy), .acc_pending(acc_pending), .hold_i(hold_i), .hlda_i(hlda_i),
    .breq_o(breq_o), .hlda_o(hlda_o), .hlda_oe(hlda_oe), .bus_drv_en(bus_drv_en)
  );

  // Monitor: compares queued expectations half a unit after each falling edge
  always @(negedge clk) begin
    #0.5;
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if ({bus_drv_en, hlda_o, hlda_oe, breq_o} !== {e.drv, e.ack, e.oe, e.req}) begin
        errors++;
        $display("FAIL %s: drv/ack/oe/req actual %b%b%b%b expected %b%b%b%b", e.tag,
                 bus_drv_en, hlda_o, hlda_oe, breq_o, e.drv, e.ack, e.oe, e.req);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver side: push an expectation for this sample point, then step past it
  task automatic expect_now(input string tag, input logic drv, input logic ack,
                            input logic oe, input logic req);
    exp_t e;
    e.tag = tag; e.drv = drv; e.ack = ack; e.oe = oe; e.req = req;
    exp_q.push_back(e);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    expect_now("R1 reset, disabled", 1, 0, 0, 0);
    rst_n = 1'b1;
    // R1: hold ignored while disabled
    hold_i = 1'b1; acc_pending = 1'b1;
    tick(6);
    expect_now("R1 hold ignored while off", 1, 0, 0, 0);
    hold_i = 1'b0; acc_pending = 1'b0;
    tick(4);
    arb_en = 1'b1;
    tick(1);
    expect_now("R2 owning role idle", 1, 0, 1, 0);

    // R4: busy sequencer blocks the grant
    seq_busy = 1'b1; hold_i = 1'b1;
    tick(6);
    expect_now("R4 busy keeps bus", 1, 0, 1, 0);
    seq_busy = 1'b0;
    tick(1);
    expect_now("R4 grant after idle", 0, 1, 1, 0);
    acc_pending = 1'b1;
    tick(1);
    expect_now("R5 request while lent", 0, 1, 1, 1);
    // R6 / R7: release hold, walk the synchroniser edges
    hold_i = 1'b0;
    tick(2);
    expect_now("R7 release not yet seen", 0, 1, 1, 1);
    tick(1);
    expect_now("R6 gap cycle", 0, 0, 1, 0);
    tick(1);
    expect_now("R6 drivers back", 1, 0, 1, 0);
    expect_now("R5 no request while owning", 1, 0, 1, 0);

    // R7: grant latency from idle
    acc_pending = 1'b0;
    hold_i = 1'b1;
    tick(2);
    expect_now("R7 two edges no grant", 1, 0, 1, 0);
    tick(1);
    expect_now("R7 third edge grant", 0, 1, 1, 0);
    hold_i = 1'b0;
    tick(5);
    expect_now("R6 back to owning", 1, 0, 1, 0);

    // Borrowing role
    slave_mode = 1'b1;
    tick(1);
    expect_now("R3 ack pin input", 0, 0, 0, 0);
    hlda_i = 1'b1;
    tick(4);
    expect_now("R8 grant without need", 0, 0, 0, 0);
    hlda_i = 1'b0;
    tick(3);
    acc_pending = 1'b1;
    #0.5;
    expect_now("R8 request follows need", 0, 0, 0, 1);
    tick(1);
    hlda_i = 1'b1;
    tick(2);
    expect_now("R7 slave grant pending", 0, 0, 0, 1);
    tick(1);
    expect_now("R8 drive on grant", 1, 0, 0, 1);
    seq_busy = 1'b1; hlda_i = 1'b0;
    tick(6);
    expect_now("R8 hold while busy", 1, 0, 0, 1);
    seq_busy = 1'b0;
    tick(1);
    expect_now("R8 release at cycle end", 0, 0, 0, 1);
    acc_pending = 1'b0;
    tick(1);
    expect_now("R8 request drops", 0, 0, 0, 0);

    arb_en = 1'b0;
    tick(1);
    expect_now("R1 disabled again", 1, 0, 0, 0);
    tick(2);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule